// File: doc/BRIEF.md
# Tri-state phase-frequency detector

This block compares the rising edges of a reference input with the rising edges of an oscillator feedback input. It produces a three-state charge-pump request. A driven-high request asks the loop to raise the oscillator frequency. A driven-low request asks it to lower the frequency. When neither request is pending, the output is released to high impedance.

A lock flag is high exactly while the pump output is released. With a locked loop, the flag stays high except for short corrections near coincident edges. Because only rising edges matter, the duty cycle of either input has no influence.

Both inputs are asynchronous to the block. Each one passes through a two-flop synchronizer and a rising-edge detector running on a fast system clock. The three-state machine that holds the pending request also runs on that clock. The pump is presented as an enable plus a data bit, ready for a pad driver elsewhere.

Top module: `pfd_tristate`

## Requirements
- R1: While `rst_n` is low, the block is idle: `pump_en`=0 and `locked`=1.
- R2: From idle, a reference rising edge alone moves the block to the up state (`pump_en`=1, `pump_val`=1). A later feedback rising edge alone returns it to idle.
- R3: From idle, a feedback rising edge alone moves the block to the down state (`pump_en`=1, `pump_val`=0). A later reference rising edge alone returns it to idle.
- R4: `locked` is 1 exactly when `pump_en` is 0.
- R5: Falling edges and held levels on either input leave the state unchanged. The state changes only in a cycle that follows a detected rising edge.
- R6: When the feedback input keeps pulsing and the reference input stays still, the output stays driven low continuously after the first feedback edge.
- R7: A further reference rising edge while in the up state keeps the output driven high until the next feedback rising edge.
- R8: Reference and feedback rising edges detected in the same cycle put the block in idle, whatever the previous state.
- R9: An input change made between clock edges reaches the outputs on the third rising clock edge after it: two synchronizer stages, then the state register.
- R10: The block never moves directly between the up and down states. While driven, `pump_val` holds its value until the output is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Oscillator feedback signal, asynchronous |
| pump_en | output | 1 | Pump drive enable; 0 means high impedance |
| pump_val | output | 1 | Pump drive level when enabled: 1 means up, 0 means down |
| locked | output | 1 | High while the pump is released |

## Verification
Any input change made on a falling clock edge shows up at the outputs exactly three rising edges later. The reference model applies the same delay: it keeps a short history of input samples and computes a rising edge from the samples taken two and three edges back. The outputs are compared on every falling edge, so each comparison sees a settled value. One directed check confirms the delay itself: the outputs must be unchanged after two edges and must have moved after the third.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PFD_IDLE = 2'b00,
    PFD_UP   = 2'b01,
    PFD_DN   = 2'b10
  } pfd_state_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q, sync_d;
  logic          prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], din};
    prev_d = sync_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic pump_en,
  output logic pump_val,
  output logic locked
);
  pfd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case ({ref_rise, fb_rise})
      2'b11: state_d = PFD_IDLE;
      2'b10: state_d = (state_q == PFD_DN) ? PFD_IDLE : PFD_UP;
      2'b01: state_d = (state_q == PFD_UP) ? PFD_IDLE : PFD_DN;
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PFD_IDLE;
    else        state_q <= state_d;
  end

  assign pump_en  = (state_q != PFD_IDLE);
  assign pump_val = (state_q == PFD_UP);
  assign locked   = (state_q == PFD_IDLE);
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic pump_en,
  output logic pump_val,
  output logic locked
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] raw_vec;
  logic [NUM_IN-1:0] rise_vec;
  logic              ref_rise;
  logic              fb_rise;

  assign raw_vec = {fb_in, ref_in};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_vec[i]),
      .rise (rise_vec[i])
    );
  end

  assign ref_rise = rise_vec[0];
  assign fb_rise  = rise_vec[1];

  pfd_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(ref_rise),
    .fb_rise (fb_rise),
    .pump_en (pump_en),
    .pump_val(pump_val),
    .locked  (locked)
  );
endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_rise,
  input logic fb_rise,
  input logic pump_en,
  input logic pump_val,
  input logic locked
);
  // R4
  lock_matches_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked == !pump_en);

  // R8
  both_edges_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise) |=> (locked && !pump_en));

  // R2
  ref_edge_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise && !pump_en) |=> (pump_en && pump_val));

  // R3
  fb_edge_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise && !pump_en) |=> (pump_en && !pump_val));

  // R5
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_rise && !fb_rise) |=> ($stable(pump_en) && $stable(pump_val)));

  // R10
  no_direct_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_en && $past(pump_en)) |-> (pump_val == $past(pump_val)));
endmodule

bind pfd_tristate pfd_tristate_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_rise(ref_rise),
  .fb_rise (fb_rise),
  .pump_en (pump_en),
  .pump_val(pump_val),
  .locked  (locked)
);

// File: tb/pfd_tristate_test.sv
module pfd_tristate_test;
  logic clk;
  logic rst_n;
  logic ref_in;
  logic fb_in;
  logic pump_en;
  logic pump_val;
  logic locked;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit started = 0;

  // reference model: 0 idle, 1 up, 2 down
  int ms = 0;
  int rh1 = 0, rh2 = 0, rh3 = 0;
  int fh1 = 0, fh2 = 0, fh3 = 0;

  pfd_tristate uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_in  (ref_in),
    .fb_in   (fb_in),
    .pump_en (pump_en),
    .pump_val(pump_val),
    .locked  (locked)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0;
      rh1 = 0; rh2 = 0; rh3 = 0;
      fh1 = 0; fh2 = 0; fh3 = 0;
    end else begin
      int r, f;
      r = (rh2 == 1 && rh3 == 0) ? 1 : 0;
      f = (fh2 == 1 && fh3 == 0) ? 1 : 0;
      if (r == 1 && f == 1) ms = 0;
      else if (r == 1) ms = (ms == 2) ? 0 : 1;
      else if (f == 1) ms = (ms == 1) ? 0 : 2;
      rh3 = rh2; rh2 = rh1; rh1 = int'(ref_in);
      fh3 = fh2; fh2 = fh1; fh1 = int'(fb_in);
    end
    started = 1;
  end

  task automatic check(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (started) begin
      check(tag, int'(pump_en), (ms != 0) ? 1 : 0, "pump_en");
      check(tag, int'(locked), (ms == 0) ? 1 : 0, "locked (R4)");
      if (ms != 0) check(tag, int'(pump_val), (ms == 1) ? 1 : 0, "pump_val");
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ref(int hi);
    ref_in = 1; wait_cyc(hi); ref_in = 0;
  endtask

  task automatic pulse_fb(int hi);
    fb_in = 1; wait_cyc(hi); fb_in = 0;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    rst_n = 0; ref_in = 0; fb_in = 0;
    wait_cyc(3);
    // R1 reset state
    check("R1", int'(pump_en), 0, "pump_en in reset");
    check("R1", int'(locked), 1, "locked in reset");
    rst_n = 1;
    wait_cyc(4);

    // R9 latency, with R2 entry into up
    tag = "R9";
    ref_in = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R9", int'(pump_en), 0, "pump_en after 2 edges");
    @(posedge clk); #1;
    check("R9", int'(pump_en), 1, "pump_en after 3 edges");
    check("R2", int'(pump_val), 1, "pump_val up");
    @(negedge clk);
    wait_cyc(3); ref_in = 0;
    tag = "R2";
    wait_cyc(6);
    pulse_fb(2);
    wait_cyc(6);
    check("R2", int'(locked), 1, "idle after feedback edge");

    // R3 down then release by reference edge
    tag = "R3";
    pulse_fb(3); wait_cyc(8);
    check("R3", int'(pump_en), 1, "driven while down");
    check("R3", int'(pump_val), 0, "level while down");
    pulse_ref(1); wait_cyc(6);
    check("R3", int'(locked), 1, "idle after reference edge");

    // R5 falling edges and long high levels do nothing
    tag = "R5";
    ref_in = 1; wait_cyc(6);
    check("R5", int'(pump_val), 1, "up after ref rise");
    ref_in = 0; wait_cyc(8);
    check("R5", int'(pump_en), 1, "ref fall leaves up");
    fb_in = 1; wait_cyc(6);
    fb_in = 0; wait_cyc(8);
    check("R5", int'(locked), 1, "fb fall leaves idle");

    // R7 extra reference edge while up
    tag = "R7";
    pulse_ref(2); wait_cyc(4);
    pulse_ref(2); wait_cyc(10);
    check("R7", int'(pump_en), 1, "still driven after extra ref edge");
    check("R7", int'(pump_val), 1, "still high after extra ref edge");
    pulse_fb(2); wait_cyc(6);
    check("R7", int'(locked), 1, "release after feedback edge");

    // R8 simultaneous edges from idle and from down
    tag = "R8";
    ref_in = 1; fb_in = 1; wait_cyc(2); ref_in = 0; fb_in = 0; wait_cyc(6);
    check("R8", int'(locked), 1, "both from idle");
    pulse_fb(2); wait_cyc(6);
    ref_in = 1; fb_in = 1; wait_cyc(2); ref_in = 0; fb_in = 0; wait_cyc(6);
    check("R8", int'(locked), 1, "both from down");
    pulse_ref(1); wait_cyc(6);
    ref_in = 1; fb_in = 1; wait_cyc(2); ref_in = 0; fb_in = 0; wait_cyc(6);
    check("R8", int'(locked), 1, "both from up");

    // R6 reference absent: continuously low
    tag = "R6";
    for (int k = 0; k < 6; k++) begin
      pulse_fb(3); wait_cyc(5);
      check("R6", int'(pump_en), 1, "driven with no reference");
      check("R6", int'(pump_val), 0, "low with no reference");
    end
    pulse_ref(2); wait_cyc(6);

    // R10 mismatched frequencies: feedback faster then slower
    tag = "R10";
    fork
      for (int k = 0; k < 8; k++) begin pulse_ref(5); wait_cyc(15); end
      for (int k = 0; k < 12; k++) begin pulse_fb(4); wait_cyc(9); end
    join
    wait_cyc(10);
    fork
      for (int k = 0; k < 12; k++) begin pulse_ref(4); wait_cyc(9); end
      for (int k = 0; k < 7; k++) begin pulse_fb(6); wait_cyc(17); end
    join
    wait_cyc(10);

    // R1 reset again from a driven state
    tag = "R1";
    pulse_fb(2); wait_cyc(6);
    rst_n = 0; wait_cyc(2);
    check("R1", int'(pump_en), 0, "pump_en after mid-run reset");
    check("R1", int'(locked), 1, "locked after mid-run reset");
    rst_n = 1; wait_cyc(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule